// File: doc/BRIEF.md
# PHY management register file

This block holds the standard control and status registers of a 10/100 Ethernet PHY and serves them through a plain word-wide register port. A management front end that has already decoded the serial frame presents a register number and a strobe. Writes take effect at the clock edge that samples the write strobe. Read data appears on `reg_rdata` one cycle after the read strobe and then holds until the next read. There is no back-pressure: every strobe is accepted in the cycle it is seen.

The register bits carry their own side effects. Some command bits clear themselves. The link bit latches low. The fault, jabber, multiple-fault and page bits clear when read. Defaults and write permissions depend on three strap inputs. The block drives the control outputs that select the operating mode of the rest of the PHY, and it exports the advertisement word for the negotiation logic. It also captures the link partner's code word whenever the negotiation logic presents one.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset with all straps high and all status inputs low, registers 0 through 6 read 0x3100, 0x7849, 0x0000, 0x8201, 0x01E1, 0x0000 and 0x0000. Register 0 bits 13, 12 and 8 take their reset value from `strap_speed100`, `strap_an_en` and `strap_full`.
- R2: Writing register 0 with bit 15 set starts a software reset. `ctl_srst_busy` is high for exactly SRST_CYCLES cycles. Bit 15 always reads 0. Every write made while busy is ignored. All registers and latched bits return to their reset values, including the strap-derived fields.
- R3: Writing register 0 with bit 9 set produces a one-cycle pulse on `ctl_an_restart`, but only when the same write leaves negotiation enabled (bit 12). Bit 9 always reads 0.
- R4: While negotiation is enabled, `ctl_speed100` and `ctl_full` follow `an_speed100` and `an_full`. Writes to bit 8 are ignored. When `an_done` is also high, bit 8 reads `an_full`. While negotiation is disabled, the outputs follow stored bits 13 and 8. Bit 14 drives `ctl_loopback` and bit 11 drives `ctl_pwrdn`.
- R5: Register 1 bit 2 drops to 0 on any cycle with `link_ok` low. It stays 0 until register 1 is read. That read reloads it from `link_ok`.
- R6: Register 1 bit 4 is set by `rfault_in` and bit 1 is set by `jabber_in`. Each stays set until a read of register 1 made while its input is low. Bit 5 reads `an_done`.
- R7: Register 6 bit 4 is set by `mlf_in` and clears on a read of register 6. Register 6 bit 1 is set by `page_in`. It clears on a read of register 5 or on any cycle with `link_ok` low. Register 6 bit 3 reads register 5 bit 15, and bit 0 reads `lp_an_able`.
- R8: In register 4, bits 13, 10 and 8:5 are writable. Bits 15, 14, 12, 11 and 9 read 0. Bits 4:0 read 00001. `adv_word` equals the register 4 read value.
- R9: Register 5 loads `lp_word` when `lp_load` is high. It reads 0 after reset, and it reads 0 after any restart pulse.
- R10: While `strap_an_en` is low, register 0 bit 12 reads 0, cannot be set, and `ctl_an_en` stays low.
- R11: While `strap_an_en` is high, a low `strap_speed100` masks register 4 bits 8 and 7, and a low `strap_full` masks bits 8 and 6, in both the read value and `adv_word`. While `strap_an_en` is low, no mask applies.
- R12: Register numbers 7 and above read 0. Register 2 reads 0x0000 and register 3 reads the PHY_ID2 parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register number |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| strap_an_en | input | 1 | Negotiation-enable strap |
| strap_speed100 | input | 1 | 100 Mb/s strap |
| strap_full | input | 1 | Full-duplex strap |
| link_ok | input | 1 | Live link-pass state |
| jabber_in | input | 1 | Jabber condition |
| rfault_in | input | 1 | Remote fault condition |
| mlf_in | input | 1 | Multiple link fault event |
| page_in | input | 1 | Page received event |
| an_done | input | 1 | Negotiation complete |
| an_speed100 | input | 1 | Negotiated speed is 100 Mb/s |
| an_full | input | 1 | Negotiated full duplex |
| lp_load | input | 1 | Capture `lp_word` |
| lp_word | input | 16 | Link partner code word |
| lp_an_able | input | 1 | Link partner can negotiate |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed100 | output | 1 | Selected speed is 100 Mb/s |
| ctl_full | output | 1 | Selected full duplex |
| ctl_an_en | output | 1 | Negotiation enabled |
| ctl_pwrdn | output | 1 | Power-down request |
| ctl_an_restart | output | 1 | One-cycle negotiation restart |
| ctl_srst_busy | output | 1 | Software reset in progress |
| adv_word | output | 16 | Local advertisement word |

## Verification
The bench builds the block with SRST_CYCLES = 8 instead of the default 250. This brings the exact length of the software-reset window within a short run: the bench checks the busy flag on the last busy cycle and on the first free cycle. It also writes inside the window to confirm the write is dropped. ADDR_W and PHY_ID2 keep their defaults, so the full register space, including the unmapped numbers at the top, is read. The strap combinations are changed in mid-run, followed by soft resets, so that the strap-derived defaults and the advertisement masking are reached without a fresh power-on reset.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W = 16;
  localparam logic [4:0] RA_CTRL = 5'd0;
  localparam logic [4:0] RA_STAT = 5'd1;
  localparam logic [4:0] RA_ID1  = 5'd2;
  localparam logic [4:0] RA_ID2  = 5'd3;
  localparam logic [4:0] RA_ADV  = 5'd4;
  localparam logic [4:0] RA_LPA  = 5'd5;
  localparam logic [4:0] RA_EXP  = 5'd6;
  localparam logic [4:0] SELECTOR = 5'b00001;
  localparam logic [4:0] STAT_ABIL = 5'b01111;
endpackage

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg #(
  parameter int SRST_CYCLES = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        w_srst,
  input  logic        w_loop,
  input  logic        w_spd,
  input  logic        w_an,
  input  logic        w_pd,
  input  logic        w_restart,
  input  logic        w_dup,
  input  logic        strap_an_en,
  input  logic        strap_speed100,
  input  logic        strap_full,
  input  logic        an_done,
  input  logic        an_speed100,
  input  logic        an_full,
  output logic [15:0] ctrl_word,
  output logic        loopback,
  output logic        speed100,
  output logic        full_dx,
  output logic        an_en,
  output logic        pwrdn,
  output logic        an_restart,
  output logic        srst_busy
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES);

  logic loop_q, spd_q, an_q, pd_q, dup_q, rs_q;
  logic [CNT_W-1:0] cnt_q;
  logic an_next, dup_rd;

  assign srst_busy = (cnt_q != '0);
  assign an_en     = an_q & strap_an_en;
  assign an_next   = strap_an_en & w_an;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      spd_q  <= strap_speed100;
      an_q   <= strap_an_en;
      pd_q   <= 1'b0;
      dup_q  <= strap_full;
      rs_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rs_q <= 1'b0;
      if (srst_busy || (wr_en && w_srst)) begin
        cnt_q  <= srst_busy ? cnt_q - CNT_W'(1) : CNT_LOAD;
        loop_q <= 1'b0;
        spd_q  <= strap_speed100;
        an_q   <= strap_an_en;
        pd_q   <= 1'b0;
        dup_q  <= strap_full;
      end else if (wr_en) begin
        loop_q <= w_loop;
        spd_q  <= w_spd;
        pd_q   <= w_pd;
        an_q   <= an_next;
        if (!an_en) dup_q <= w_dup;
        rs_q   <= w_restart & an_next;
      end
    end
  end

  assign dup_rd     = (an_en && an_done) ? an_full : dup_q;
  assign ctrl_word  = {1'b0, loop_q, spd_q, an_en, pd_q, 2'b00, dup_rd, 8'h00};
  assign loopback   = loop_q;
  assign pwrdn      = pd_q;
  assign speed100   = an_en ? an_speed100 : spd_q;
  assign full_dx    = an_en ? an_full : dup_q;
  assign an_restart = rs_q;

  AST_BUSY_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && wr_en) |=> $stable(loopback) && $stable(pwrdn)); // R2
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> !an_restart); // R2
  AST_RESTART_NEEDS_AN: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |-> an_en); // R3
endmodule

// File: rtl/phy_sts_latch.sv
module phy_sts_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rd_stat,
  input  logic rd_lpa,
  input  logic rd_exp,
  input  logic link_ok,
  input  logic jabber_in,
  input  logic rfault_in,
  input  logic mlf_in,
  input  logic page_in,
  output logic lnk,
  output logic jab,
  output logic rf,
  output logic mlf,
  output logic page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lnk <= 1'b0; jab <= 1'b0; rf <= 1'b0; mlf <= 1'b0; page <= 1'b0;
    end else if (clr) begin
      lnk <= 1'b0; jab <= 1'b0; rf <= 1'b0; mlf <= 1'b0; page <= 1'b0;
    end else begin
      lnk  <= rd_stat ? link_ok : (lnk & link_ok);
      jab  <= jabber_in | (jab & ~rd_stat);
      rf   <= rfault_in | (rf & ~rd_stat);
      mlf  <= mlf_in | (mlf & ~rd_exp);
      page <= page_in | (page & ~rd_lpa & link_ok);
    end
  end

  AST_LINK_DROP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> !lnk); // R5
  AST_RFAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rf && !rd_stat && !clr) |=> rf); // R6
  AST_PAGE_LINK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ok && !page_in) |=> !page); // R7
endmodule

// File: rtl/phy_adv_lp.sv
module phy_adv_lp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_adv,
  input  logic        w_rf,
  input  logic        w_pause,
  input  logic [3:0]  w_abil,
  input  logic        strap_an_en,
  input  logic        strap_speed100,
  input  logic        strap_full,
  input  logic        an_restart,
  input  logic        lp_load,
  input  logic [15:0] lp_word,
  output logic [15:0] adv_word,
  output logic [15:0] lp_q
);
  import phy_mgmt_pkg::*;

  logic       rf_q, pause_q;
  logic [3:0] abil_q, abil_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q <= 1'b0; pause_q <= 1'b0; abil_q <= 4'hF; lp_q <= '0;
    end else if (clr) begin
      rf_q <= 1'b0; pause_q <= 1'b0; abil_q <= 4'hF; lp_q <= '0;
    end else begin
      if (wr_adv) begin
        rf_q    <= w_rf;
        pause_q <= w_pause;
        abil_q  <= w_abil;
      end
      if (an_restart)   lp_q <= '0;
      else if (lp_load) lp_q <= lp_word;
    end
  end

  // abil index 3: 100 full, 2: 100 half, 1: 10 full, 0: 10 half
  always_comb begin
    abil_mask = 4'hF;
    if (strap_an_en) begin
      if (!strap_speed100) abil_mask[3:2] = 2'b00;
      if (!strap_full) begin
        abil_mask[3] = 1'b0;
        abil_mask[1] = 1'b0;
      end
    end
  end

  assign adv_word = {2'b00, rf_q, 2'b00, pause_q, 1'b0, abil_q & abil_mask, SELECTOR};

  AST_LP_CLEARED_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> (lp_q == '0)); // R9
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int          ADDR_W      = 5,
  parameter int          SRST_CYCLES = 250,
  parameter logic [15:0] PHY_ID2     = 16'h8201
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [15:0]       reg_rdata,
  input  logic              strap_an_en,
  input  logic              strap_speed100,
  input  logic              strap_full,
  input  logic              link_ok,
  input  logic              jabber_in,
  input  logic              rfault_in,
  input  logic              mlf_in,
  input  logic              page_in,
  input  logic              an_done,
  input  logic              an_speed100,
  input  logic              an_full,
  input  logic              lp_load,
  input  logic [15:0]       lp_word,
  input  logic              lp_an_able,
  output logic              ctl_loopback,
  output logic              ctl_speed100,
  output logic              ctl_full,
  output logic              ctl_an_en,
  output logic              ctl_pwrdn,
  output logic              ctl_an_restart,
  output logic              ctl_srst_busy,
  output logic [15:0]       adv_word
);
  import phy_mgmt_pkg::*;

  logic [15:0] ctrl_word, lp_q, rd_mux, stat_word, exp_word;
  logic sel_ctrl, sel_stat, sel_adv, sel_lpa, sel_exp;
  logic lnk, jab, rf, mlf, page;
  logic unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata[4:0]};

  assign sel_ctrl = (reg_addr == ADDR_W'(RA_CTRL));
  assign sel_stat = (reg_addr == ADDR_W'(RA_STAT));
  assign sel_adv  = (reg_addr == ADDR_W'(RA_ADV));
  assign sel_lpa  = (reg_addr == ADDR_W'(RA_LPA));
  assign sel_exp  = (reg_addr == ADDR_W'(RA_EXP));

  phy_ctl_reg #(.SRST_CYCLES(SRST_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_ctrl),
    .w_srst(reg_wdata[15]), .w_loop(reg_wdata[14]), .w_spd(reg_wdata[13]),
    .w_an(reg_wdata[12]), .w_pd(reg_wdata[11]), .w_restart(reg_wdata[9]),
    .w_dup(reg_wdata[8]),
    .strap_an_en(strap_an_en), .strap_speed100(strap_speed100), .strap_full(strap_full),
    .an_done(an_done), .an_speed100(an_speed100), .an_full(an_full),
    .ctrl_word(ctrl_word), .loopback(ctl_loopback), .speed100(ctl_speed100),
    .full_dx(ctl_full), .an_en(ctl_an_en), .pwrdn(ctl_pwrdn),
    .an_restart(ctl_an_restart), .srst_busy(ctl_srst_busy)
  );

  phy_sts_latch u_sts (
    .clk(clk), .rst_n(rst_n), .clr(ctl_srst_busy),
    .rd_stat(reg_rd && sel_stat), .rd_lpa(reg_rd && sel_lpa), .rd_exp(reg_rd && sel_exp),
    .link_ok(link_ok), .jabber_in(jabber_in), .rfault_in(rfault_in),
    .mlf_in(mlf_in), .page_in(page_in),
    .lnk(lnk), .jab(jab), .rf(rf), .mlf(mlf), .page(page)
  );

  phy_adv_lp u_adv (
    .clk(clk), .rst_n(rst_n), .clr(ctl_srst_busy),
    .wr_adv(reg_wr && sel_adv && !ctl_srst_busy),
    .w_rf(reg_wdata[13]), .w_pause(reg_wdata[10]), .w_abil(reg_wdata[8:5]),
    .strap_an_en(strap_an_en), .strap_speed100(strap_speed100), .strap_full(strap_full),
    .an_restart(ctl_an_restart), .lp_load(lp_load), .lp_word(lp_word),
    .adv_word(adv_word), .lp_q(lp_q)
  );

  assign stat_word = {STAT_ABIL, 4'b0000, 1'b1, an_done, rf, 1'b1, lnk, jab, 1'b1};
  assign exp_word  = {11'd0, mlf, lp_q[15], 1'b0, page, lp_an_able};

  always_comb begin
    rd_mux = '0;
    if (reg_addr < ADDR_W'(7)) begin
      unique case (reg_addr[2:0])
        3'd0:    rd_mux = ctrl_word;
        3'd1:    rd_mux = stat_word;
        3'd2:    rd_mux = 16'h0000;
        3'd3:    rd_mux = PHY_ID2;
        3'd4:    rd_mux = adv_word;
        3'd5:    rd_mux = lp_q;
        3'd6:    rd_mux = exp_word;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_SELFCLR_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel_ctrl) |=> (reg_rdata[15] == 1'b0) && (reg_rdata[9] == 1'b0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr >= ADDR_W'(7)) |=> (reg_rdata == '0)); // R12
endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
  localparam int SRST = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, lp_word = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic strap_an_en = 1, strap_speed100 = 1, strap_full = 1;
  logic link_ok = 0, jabber_in = 0, rfault_in = 0, mlf_in = 0, page_in = 0;
  logic an_done = 0, an_speed100 = 0, an_full = 0, lp_load = 0, lp_an_able = 0;
  logic [15:0] reg_rdata, adv_word;
  logic ctl_loopback, ctl_speed100, ctl_full, ctl_an_en, ctl_pwrdn, ctl_an_restart, ctl_srst_busy;

  int n_chk = 0, n_fail = 0, n_restart = 0;
  logic [15:0] q_exp[$];
  string q_tag[$];
  logic pend = 0;

  always #2 clk = ~clk;

  phy_mgmt_regs #(.SRST_CYCLES(SRST)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .strap_an_en(strap_an_en), .strap_speed100(strap_speed100), .strap_full(strap_full),
    .link_ok(link_ok), .jabber_in(jabber_in), .rfault_in(rfault_in), .mlf_in(mlf_in),
    .page_in(page_in), .an_done(an_done), .an_speed100(an_speed100), .an_full(an_full),
    .lp_load(lp_load), .lp_word(lp_word), .lp_an_able(lp_an_able),
    .ctl_loopback(ctl_loopback), .ctl_speed100(ctl_speed100), .ctl_full(ctl_full),
    .ctl_an_en(ctl_an_en), .ctl_pwrdn(ctl_pwrdn), .ctl_an_restart(ctl_an_restart),
    .ctl_srst_busy(ctl_srst_busy), .adv_word(adv_word)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each read strobe
  always @(negedge clk) begin
    if (pend) begin
      if (q_exp.size() == 0) chk("scoreboard underrun", 16'h0, 16'h1);
      else chk(q_tag.pop_front(), reg_rdata, q_exp.pop_front());
    end
    pend = reg_rd;
    if (ctl_an_restart) n_restart++;
  end

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1; q_exp.push_back(exp); q_tag.push_back(tag);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0;
    idle(3); rst_n = 1; idle(2);
    // R1 reset values
    rd(0, 16'h3100, "R1 ctrl"); rd(1, 16'h7849, "R1 stat");
    rd(2, 16'h0000, "R1 id1");  rd(3, 16'h8201, "R12 id2");
    rd(4, 16'h01E1, "R1 adv");  rd(5, 16'h0000, "R1 lpa"); rd(6, 16'h0000, "R1 exp");
    // R5 latched-low link
    link_ok = 1;
    rd(1, 16'h7849, "R5 first read after up"); rd(1, 16'h784D, "R5 live up");
    link_ok = 0; idle(1); link_ok = 1;
    rd(1, 16'h7849, "R5 latched low"); rd(1, 16'h784D, "R5 reloaded");
    // R6 remote fault and jabber
    rfault_in = 1; idle(1); rfault_in = 0;
    rd(1, 16'h785D, "R6 rfault set"); rd(1, 16'h784D, "R6 rfault cleared");
    jabber_in = 1; idle(1); jabber_in = 0;
    rd(1, 16'h784F, "R6 jabber set"); rd(1, 16'h784D, "R6 jabber cleared");
    rfault_in = 1;
    rd(1, 16'h785D, "R6 rfault held a"); rd(1, 16'h785D, "R6 rfault held b");
    rfault_in = 0;
    rd(1, 16'h785D, "R6 rfault last"); rd(1, 16'h784D, "R6 rfault gone");
    // R7 expansion bits
    mlf_in = 1; idle(1); mlf_in = 0;
    rd(6, 16'h0010, "R7 mlf set"); rd(6, 16'h0000, "R7 mlf cleared");
    page_in = 1; idle(1); page_in = 0;
    rd(6, 16'h0002, "R7 page set"); rd(6, 16'h0002, "R7 page kept on exp read");
    rd(5, 16'h0000, "R9 lpa empty"); rd(6, 16'h0000, "R7 page cleared by lpa read");
    page_in = 1; idle(1); page_in = 0;
    link_ok = 0; idle(1); link_ok = 1;
    rd(6, 16'h0000, "R7 page cleared by link loss");
    rd(1, 16'h7849, "R5 after loss");
    // R9 link partner word
    lp_word = 16'hC5E1; lp_load = 1; idle(1); lp_load = 0;
    rd(5, 16'hC5E1, "R9 lpa loaded"); rd(6, 16'h0008, "R7 lp next-page bit");
    lp_an_able = 1; rd(6, 16'h0009, "R7 lp able"); lp_an_able = 0;
    r0 = n_restart;
    wr(0, 16'h1200); idle(2);
    chk("R3 restart pulse count", 16'(n_restart - r0), 16'd1);
    rd(5, 16'h0000, "R9 lpa cleared by restart");
    rd(0, 16'h1100, "R3 restart bit reads 0");
    // R4 negotiated mode
    an_done = 1; an_full = 0; an_speed100 = 1;
    rd(0, 16'h1000, "R4 duplex shows negotiated");
    chk("R4 speed follows negotiation", {15'd0, ctl_speed100}, 16'd1);
    chk("R4 duplex follows negotiation", {15'd0, ctl_full}, 16'd0);
    wr(0, 16'h1000); an_done = 0;
    rd(0, 16'h1100, "R4 duplex write ignored");
    // R3 negative: restart with negotiation off
    r0 = n_restart;
    wr(0, 16'h0200); idle(2);
    chk("R3 no pulse when disabled", 16'(n_restart - r0), 16'd0);
    rd(0, 16'h0100, "R3 ctrl after disable");
    chk("R4 forced speed", {15'd0, ctl_speed100}, 16'd0);
    chk("R4 forced duplex", {15'd0, ctl_full}, 16'd1);
    wr(0, 16'h4800);
    rd(0, 16'h4800, "R4 loop and powerdown");
    chk("R4 loopback out", {15'd0, ctl_loopback}, 16'd1);
    chk("R4 powerdown out", {15'd0, ctl_pwrdn}, 16'd1);
    chk("R4 forced half", {15'd0, ctl_full}, 16'd0);
    // R8 advertisement fields
    wr(4, 16'hFFFF); rd(4, 16'h25E1, "R8 all ones");
    chk("R8 adv_word", adv_word, 16'h25E1);
    wr(4, 16'h0000); rd(4, 16'h0001, "R8 all zeros");
    // R11 strap masking
    wr(4, 16'h01E0); rd(4, 16'h01E1, "R11 unmasked");
    strap_speed100 = 0; rd(4, 16'h0061, "R11 no 100");
    strap_full = 0; rd(4, 16'h0021, "R11 no 100 no full");
    chk("R11 adv_word masked", adv_word, 16'h0021);
    strap_speed100 = 1; rd(4, 16'h00A1, "R11 no full");
    strap_full = 1;
    wr(4, 16'h2400); rd(4, 16'h2401, "R8 rf and pause");
    // R2 software reset
    wr(0, 16'h8000);
    chk("R2 busy start", {15'd0, ctl_srst_busy}, 16'd1);
    idle(SRST - 1);
    chk("R2 busy last cycle", {15'd0, ctl_srst_busy}, 16'd1);
    idle(1);
    chk("R2 busy ended", {15'd0, ctl_srst_busy}, 16'd0);
    rd(0, 16'h3100, "R2 ctrl restored");
    rd(1, 16'h7849, "R2 link latch cleared");
    rd(4, 16'h01E1, "R2 adv restored");
    wr(0, 16'h8000); wr(0, 16'h4000); idle(SRST + 2);
    rd(0, 16'h3100, "R2 write while busy ignored");
    chk("R2 loopback stays off", {15'd0, ctl_loopback}, 16'd0);
    // R10 negotiation strap low
    strap_an_en = 0;
    wr(0, 16'h8000); idle(SRST + 2);
    rd(0, 16'h2100, "R10 strap default");
    wr(0, 16'h1000); rd(0, 16'h0000, "R10 bit12 cannot set");
    chk("R10 an_en low", {15'd0, ctl_an_en}, 16'd0);
    strap_speed100 = 0; rd(4, 16'h01E1, "R11 no mask with strap low");
    strap_speed100 = 1;
    // R12 unmapped
    rd(7, 16'h0000, "R12 addr 7"); rd(31, 16'h0000, "R12 addr 31");
    idle(4);
    chk("scoreboard drained", 16'(q_exp.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule